// File: doc/BRIEF.md
# Time-Slot Sequencing Timer

This block steps a processor through a fixed, repeating table of time slots. Every slot is split into two phases. In the first phase a scheduler countdown runs for a single programmed length. When it expires, the block emits a one-cycle dispatch strobe that carries the current slot number, so software can run the work list that belongs to that slot. The block then enters the second phase. There a per-slot countdown runs for that slot's own programmed length. When it expires, the slot number advances, wrapping after the last slot, and the first phase of the next slot begins.

Durations are counts of clock cycles and are held in a small register bank. Software writes them while the sequencer is disabled. Raising the enable input starts the sequence from slot 0 in the first phase. Every phase event raises an interrupt that stays high until it is acknowledged. An event that arrives while the interrupt is still pending is counted as an overrun.

Top module: `tdma_slot_sequencer`

## Requirements
- R1: After reset, and while enable is low, slot_idx is 0, phase_end is 0 (first phase), dispatch_valid is 0; after reset irq is 0 and overrun_cnt is 0.
- R2: After enable is first sampled high, the first phase lasts exactly max(scheduler duration,1) cycles; it then ends with dispatch_valid high for one cycle, dispatch_slot equal to slot_idx, and phase_end becoming 1 in the same cycle.
- R3: The second phase lasts exactly max(duration of the current slot,1) cycles; it then ends with slot_idx advancing by one and phase_end returning to 0, after which the first phase of the new slot runs again.
- R4: After slot NUM_SLOTS-1 the slot index wraps to 0.
- R5: Each slot's second phase uses that slot's own register, written at configuration address equal to the slot number (0 to NUM_SLOTS-1).
- R6: A programmed duration of 0 behaves as 1 cycle for both the scheduler and the slot durations.
- R7: Configuration address 8 holds the scheduler duration; writes to any other address at or above NUM_SLOTS, and all writes while enable is high, change nothing.
- R8: irq rises in the cycle of every phase event (dispatch or slot advance) and stays high until irq_ack is sampled high with no event in that cycle, which clears it.
- R9: An event while irq is already high and irq_ack is low increments overrun_cnt, which saturates at its maximum; an event in the same cycle as irq_ack keeps irq high and does not count as an overrun.
- R10: Lowering enable returns the sequencer to slot 0 and the first phase on the next cycle; re-enabling restarts the full timing from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the sequencer; low holds it at its initial state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address: slot number, or 8 for the scheduler |
| cfg_wdata | input | DUR_W (16) | Duration in cycles |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| slot_idx | output | SLOT_W (2) | Current slot number |
| phase_end | output | 1 | 0 in the first phase, 1 in the second phase |
| dispatch_valid | output | 1 | One-cycle strobe at the end of the first phase |
| dispatch_slot | output | SLOT_W (2) | Slot number carried by the dispatch strobe |
| irq | output | 1 | Pending phase-event interrupt |
| overrun_cnt | output | CNT_W (8) | Saturating count of events lost while irq was pending |

## Verification
Two things can land in the same clock cycle: a phase event from either countdown and the acknowledge of the previous interrupt. The bench provokes this by holding irq pending, then timing irq_ack so that it is sampled on the exact edge where the first-phase countdown expires. That edge is known from the programmed scheduler length. The case is judged at the ports: irq must still be high afterwards and overrun_cnt must be unchanged. On the following event, with the acknowledge absent and irq still pending, overrun_cnt must rise by exactly one.

// File: rtl/tdma_seq_pkg.sv
// Shared definitions for the time-slot sequencer.
// Assumes at most eight slots, so a 4-bit configuration address suffices.
package tdma_seq_pkg;
    localparam int MAX_SLOTS     = 8;
    localparam int CFG_ADDR_W    = 4;
    localparam int SCHED_REG_ADDR = 8;

    typedef enum logic {
        PH_START = 1'b0,
        PH_END   = 1'b1
    } phase_e;
endpackage

// File: rtl/tdma_dur_regs.sv
// Duration register bank: one register per slot plus the scheduler register.
// Assumes the caller gates wr_en so that writes only occur while disabled.
module tdma_dur_regs #(
    parameter int NUM_SLOTS = 4,
    parameter int DUR_W     = 16,
    parameter int ADDR_W    = 4,
    parameter int SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DUR_W-1:0]  wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DUR_W-1:0]  rd_dur,
    output logic [DUR_W-1:0]  sched_dur
);
    logic [DUR_W-1:0] slot_dur_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_reg
        // Hold the programmed duration of slot g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_dur_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                slot_dur_q[g] <= wr_data;
        end
    end

    // Hold the scheduler duration.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sched_dur <= '0;
        else if (wr_en && wr_addr == ADDR_W'(tdma_seq_pkg::SCHED_REG_ADDR))
            sched_dur <= wr_data;
    end

    // Select the duration of the requested slot.
    always_comb begin
        rd_dur = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (rd_slot == SLOT_W'(i))
                rd_dur = slot_dur_q[i];
    end
endmodule

// File: rtl/tdma_phase_timer.sv
// Down-counting phase timer. A load sets the count to the given duration,
// with zero treated as one. While run is high it counts down and flags
// expire in its final cycle. Assumes the owner reloads it on expiry.
module tdma_phase_timer #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DUR_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] eff_val;

    // Map a zero duration onto one cycle.
    always_comb eff_val = (load_val == '0) ? DUR_W'(1) : load_val;

    // Flag the last cycle of a running countdown.
    always_comb expire = run && (cnt_q == DUR_W'(1));

    // Load or step the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= DUR_W'(1);
        else if (load)
            cnt_q <= eff_val;
        else if (run && cnt_q != DUR_W'(1))
            cnt_q <= cnt_q - DUR_W'(1);
    end
endmodule

// File: rtl/tdma_irq_ctrl.sv
// Interrupt latch with acknowledge and a saturating overrun counter.
// A new event wins over an acknowledge in the same cycle.
module tdma_irq_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [CNT_W-1:0] overrun_o
);
    // Set on an event, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else if (event_i)
            irq_o <= 1'b1;
        else if (ack_i)
            irq_o <= 1'b0;
    end

    // Count events that land on an unacknowledged interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun_o <= '0;
        else if (event_i && irq_o && !ack_i && overrun_o != {CNT_W{1'b1}})
            overrun_o <= overrun_o + CNT_W'(1);
    end
endmodule

// File: rtl/tdma_slot_sequencer.sv
// Time-slot sequencer top. Each slot runs a first phase timed by the
// scheduler duration, which ends with a dispatch strobe, and then a second
// phase timed by the slot's own duration, which ends with a slot advance.
// Assumes durations are written only while enable is low.
module tdma_slot_sequencer #(
    parameter int NUM_SLOTS = 4,
    parameter int DUR_W     = 16,
    parameter int CNT_W     = 8,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int ADDR_W   = tdma_seq_pkg::CFG_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DUR_W-1:0]  cfg_wdata,
    input  logic              irq_ack,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              phase_end,
    output logic              dispatch_valid,
    output logic [SLOT_W-1:0] dispatch_slot,
    output logic              irq,
    output logic [CNT_W-1:0]  overrun_cnt
);
    import tdma_seq_pkg::*;

    phase_e            phase_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] next_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic [DUR_W-1:0]  rd_dur;
    logic [DUR_W-1:0]  sched_dur;
    logic              sched_run, slot_run;
    logic              sched_exp, slot_exp;
    logic              timers_load;
    logic              phase_event;

    // Next slot number, wrapping after the last slot.
    always_comb
        next_slot = (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + SLOT_W'(1);

    // Timer control: both reload while disabled and on every slot advance.
    always_comb begin
        sched_run   = enable && (phase_q == PH_START);
        slot_run    = enable && (phase_q == PH_END);
        timers_load = !enable || slot_exp;
        rd_slot     = enable ? next_slot : '0;
        phase_event = sched_exp || slot_exp;
    end

    tdma_dur_regs #(
        .NUM_SLOTS(NUM_SLOTS), .DUR_W(DUR_W), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && !enable), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .rd_slot(rd_slot), .rd_dur(rd_dur), .sched_dur(sched_dur)
    );

    tdma_phase_timer #(.DUR_W(DUR_W)) u_sched_tmr (
        .clk(clk), .rst_n(rst_n), .load(timers_load), .load_val(sched_dur),
        .run(sched_run), .expire(sched_exp)
    );

    tdma_phase_timer #(.DUR_W(DUR_W)) u_slot_tmr (
        .clk(clk), .rst_n(rst_n), .load(timers_load), .load_val(rd_dur),
        .run(slot_run), .expire(slot_exp)
    );

    tdma_irq_ctrl #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .event_i(phase_event), .ack_i(irq_ack),
        .irq_o(irq), .overrun_o(overrun_cnt)
    );

    // Phase and slot state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase_q <= PH_START;
            slot_q  <= '0;
        end else if (sched_exp) begin
            phase_q <= PH_END;
        end else if (slot_exp) begin
            phase_q <= PH_START;
            slot_q  <= next_slot;
        end
    end

    // One-cycle dispatch strobe carrying the slot number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dispatch_valid <= 1'b0;
            dispatch_slot  <= '0;
        end else begin
            dispatch_valid <= sched_exp;
            if (sched_exp)
                dispatch_slot <= slot_q;
        end
    end

    assign slot_idx  = slot_q;
    assign phase_end = (phase_q == PH_END);
endmodule

// File: rtl/tdma_slot_sequencer_chk.sv
// Assertion checker for the time-slot sequencer, bound to every instance.
module tdma_slot_sequencer_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int CNT_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              irq_ack,
    input logic [SLOT_W-1:0] slot_idx,
    input logic              phase_end,
    input logic              dispatch_valid,
    input logic [SLOT_W-1:0] dispatch_slot,
    input logic              irq,
    input logic [CNT_W-1:0]  overrun_cnt
);
    // R1 / R10: disabled means back at slot 0, first phase, no dispatch.
    a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (slot_idx == '0 && !phase_end && !dispatch_valid));

    // R2: dispatch coincides with the second phase and the current slot.
    a_r2_dispatch_phase: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> (phase_end && dispatch_slot == slot_idx));

    // R2: the dispatch strobe is never longer than one cycle.
    a_r2_dispatch_single: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |=> !dispatch_valid);

    // R4: slot index stays inside the table.
    a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot_idx) < NUM_SLOTS);

    // R3 / R4: a slot change while running is a step of one with wrap.
    a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && slot_idx != $past(slot_idx)) |->
        (int'(slot_idx) == (int'($past(slot_idx)) + 1) % NUM_SLOTS));

    // R8: a pending interrupt without acknowledge stays pending.
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R8: a dispatch is always accompanied by a pending interrupt.
    a_r8_irq_on_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |-> irq);

    // R9: the overrun counter never decreases.
    a_r9_overrun_mono: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_cnt >= $past(overrun_cnt));
endmodule

bind tdma_slot_sequencer tdma_slot_sequencer_chk #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irq_ack(irq_ack),
    .slot_idx(slot_idx), .phase_end(phase_end), .dispatch_valid(dispatch_valid),
    .dispatch_slot(dispatch_slot), .irq(irq), .overrun_cnt(overrun_cnt)
);

// File: tb/tdma_slot_sequencer_bench.sv
`timescale 1ns/1ps
// Directed bench for the time-slot sequencer; one task per scenario.
module tdma_slot_sequencer_bench;
    localparam int NS = 4;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          irq_ack = 1'b0;
    logic [SW-1:0] slot_idx;
    logic          phase_end;
    logic          dispatch_valid;
    logic [SW-1:0] dispatch_slot;
    logic          irq;
    logic [CW-1:0] overrun_cnt;

    int checks = 0;
    int fails  = 0;
    int sdur [NS] = '{5, 2, 7, 4};

    always #2.5 clk = ~clk;

    tdma_slot_sequencer #(.NUM_SLOTS(NS), .DUR_W(DW), .CNT_W(CW)) u_tdma_slot_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_ack(irq_ack),
        .slot_idx(slot_idx), .phase_end(phase_end), .dispatch_valid(dispatch_valid),
        .dispatch_slot(dispatch_slot), .irq(irq), .overrun_cnt(overrun_cnt)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = DW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Count cycles until a dispatch strobe is seen.
    task automatic wait_dispatch(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!dispatch_valid && n < 2000);
    endtask

    // Count cycles until the slot index changes.
    task automatic wait_slot(output int n);
        logic [SW-1:0] old;
        old = slot_idx;
        n = 0;
        do begin @(negedge clk); n++; end while (slot_idx == old && n < 2000);
    endtask

    task automatic restart();
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 slot", slot_idx, 0);
        chk("R1 phase", phase_end, 0);
        chk("R1 dispatch", dispatch_valid, 0);
        chk("R1 irq", irq, 0);
        chk("R1 overrun", overrun_cnt, 0);
    endtask

    task automatic t_sequence();
        int n;
        wr(8, 3);
        for (int s = 0; s < NS; s++) wr(s, sdur[s]);
        wr(4, 9); // R7: address beyond the slot table, must change nothing
        @(negedge clk); enable = 1'b1;
        wait_dispatch(n);
        chk("R2 first phase length", n, 3);
        chk("R2 dispatch slot", dispatch_slot, 0);
        chk("R2 phase after dispatch", phase_end, 1);
        chk("R8 irq on event", irq, 1);
        for (int s = 0; s < NS; s++) begin
            wait_slot(n);
            chk($sformatf("R5 slot %0d length", s), n, sdur[s]);
            chk("R3 slot advance", slot_idx, (s + 1) % NS);
            chk("R3 back to first phase", phase_end, 0);
            if (s < NS - 1) begin
                wait_dispatch(n);
                chk("R2 first phase length", n, 3);
                chk("R2 dispatch slot", dispatch_slot, s + 1);
            end
        end
        chk("R4 wrap to slot 0", slot_idx, 0);
    endtask

    task automatic t_disable_and_locked_writes();
        int n;
        wr(8, 11); // R7: ignored while enabled
        wr(0, 1);  // R7: ignored while enabled
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        chk("R10 slot after disable", slot_idx, 0);
        chk("R10 phase after disable", phase_end, 0);
        enable = 1'b1;
        wait_dispatch(n);
        chk("R7 scheduler unchanged by locked write", n, 3);
        chk("R10 restart slot", dispatch_slot, 0);
        wait_slot(n);
        chk("R7 slot 0 unchanged", n, sdur[0]);
    endtask

    task automatic t_zero();
        int n;
        @(negedge clk); enable = 1'b0;
        wr(8, 0); wr(0, 0);
        @(negedge clk); enable = 1'b1;
        wait_dispatch(n);
        chk("R6 zero scheduler duration", n, 1);
        wait_slot(n);
        chk("R6 zero slot duration", n, 1);
    endtask

    task automatic t_ack_collision();
        int ov0;
        @(negedge clk); enable = 1'b0;
        wr(8, 4); wr(0, 4);
        @(negedge clk);
        chk("R8 irq still pending before collision", irq, 1);
        ov0 = overrun_cnt;
        enable = 1'b1;               // negedge 0
        repeat (3) @(negedge clk);   // negedge 3
        irq_ack = 1'b1;
        @(negedge clk);              // negedge 4: event edge saw ack
        irq_ack = 1'b0;
        chk("R9 collision dispatch", dispatch_valid, 1);
        chk("R9 collision irq kept", irq, 1);
        chk("R9 collision no overrun", overrun_cnt, ov0);
        @(negedge clk); irq_ack = 1'b1;  // negedge 5
        @(negedge clk); irq_ack = 1'b0;  // negedge 6
        chk("R8 ack clears irq", irq, 0);
        @(negedge clk);                  // negedge 7
        chk("R8 irq stays low", irq, 0);
        @(negedge clk);                  // negedge 8: slot event
        chk("R8 irq on slot event", irq, 1);
        chk("R9 no overrun when clear", overrun_cnt, ov0);
        repeat (3) @(negedge clk);       // negedge 11
        chk("R8 irq held", irq, 1);
        @(negedge clk);                  // negedge 12: dispatch, pending
        chk("R9 overrun counted", overrun_cnt, ov0 + 1);
    endtask

    task automatic t_saturate();
        @(negedge clk); enable = 1'b0;
        wr(8, 1);
        for (int s = 0; s < NS; s++) wr(s, 1);
        @(negedge clk); enable = 1'b1;
        repeat (600) @(negedge clk);
        chk("R9 overrun saturates", overrun_cnt, 255);
        chk("R8 irq pending", irq, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_sequence();
        t_disable_and_locked_writes();
        t_zero();
        t_ack_collision();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule